// File: doc/BRIEF.md
# Machine-Mode Trap Entry Controller

This block performs the state update a hart makes when it takes a trap into machine mode. A one-cycle trap strobe carries the cause, the async/sync flag and the hart's current PC, privilege and virtualization state. In the same clock the block commits three things: the new machine status and cause registers, the saved exception PC, and the new PC and privilege. A pending resumable non-maskable interrupt (RNMI) bypasses the ordinary path. In that case the RNMI status, cause and saved PC registers are written instead.

A trap can arrive while the machine disable-trap flag (MDT) in the status word is already set. With double-trap handling switched on, that trap is not taken the ordinary way. It becomes an RNMI entry if RNMI support is available and the hart is not already inside an RNMI handler. Otherwise it sets a fatal-abort flag. That flag stays set until reset, and the block takes no further state changes.

Field positions used throughout:
- Status word: MIE at bit 3, MPIE at bit 7, MDT at bit 10, MPP at bits 12:11.
- RNMI status word: NMIE at bit 3, MNPV at bit 7, MNPELP at bit 9, MNPP at bits 12:11.
- Privilege codes: 2'b11 machine, 2'b01 supervisor, 2'b00 user.

Top module: `mtrap_entry_ctrl`

## Requirements
- R1: After reset:
  - pc_o equals RESET_VEC, priv_o is 2'b11 and virt_o is 0.
  - mstatus_o holds only MIE (bit 3), equal to RESET_MIE. MDT is clear.
  - mnstatus_o has only NMIE (bit 3) set.
  - mcause_o, mepc_o, mncause_o and mnepc_o are 0, and abort_o is 0.
- R2: A trap with rnmi_en_i, rnmi_pending_i and trap_async_i all high takes the RNMI path. It clears NMIE, sets MNPV to cur_virt_i and MNPP to cur_priv_i, writes mnepc_o with cur_pc_i, writes mncause_o as the cause with bit XLEN-1 set, and loads pc_o from RNMI_VEC. mstatus_o, mcause_o and mepc_o keep their values.
- R3: On any RNMI entry with fcfi_en_i high, MNPELP (bit 9) takes lp_expected_i. With fcfi_en_i low, MNPELP keeps its value.
- R4: Every RNMI entry sets priv_o to 2'b11 and virt_o to 0.
- R5: An ordinary trap writes the status word as follows: MPIE takes the old MIE, MPP takes cur_priv_i and MIE is cleared. It also writes mepc_o with cur_pc_i, loads pc_o from TRAP_VEC, sets priv_o to 2'b11 and clears virt_o.
- R6: An ordinary trap writes mcause_o with the cause in bits XLEN-2:0 and trap_async_i in bit XLEN-1.
- R7: With dbltrap_en_i high and MDT clear, an ordinary trap also sets MDT.
- R8: With dbltrap_en_i high and MDT set, a trap sets abort_o and leaves every other output unchanged in either of two cases:
  - rnmi_en_i is low;
  - the trap is synchronous with NMIE clear.
- R9: With dbltrap_en_i high and MDT set, a trap not covered by R2 or R8 takes RNMI entry. That entry uses the raw cause (mncause_o bit XLEN-1 is 0) and sets MNPV to 0. mstatus_o keeps its value.
- R10: Once abort_o is set it stays set until reset, and later trap strobes change no output.
- R11: With trap_valid_i low, no output changes.
- R12: With dbltrap_en_i low, MDT is never modified and abort_o never rises.
- R13: A trap with dbltrap_en_i high and MDT set occurs only while cur_priv_i is machine mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid_i | input | 1 | Trap request strobe, one cycle per trap |
| trap_async_i | input | 1 | 1 for interrupt, 0 for exception |
| trap_cause_i | input | XLEN-1 | Cause code |
| cur_pc_i | input | XLEN | PC of the trapping point |
| cur_priv_i | input | 2 | Current privilege code |
| cur_virt_i | input | 1 | Current virtualization state |
| lp_expected_i | input | 1 | Landing-pad expected flag |
| fcfi_en_i | input | 1 | Forward control-flow integrity enable |
| dbltrap_en_i | input | 1 | Double-trap handling enable |
| rnmi_en_i | input | 1 | RNMI support enable |
| rnmi_pending_i | input | 1 | RNMI pending line |
| mstatus_o | output | XLEN | Machine status word |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine exception PC |
| mnstatus_o | output | XLEN | RNMI status word |
| mncause_o | output | XLEN | RNMI cause |
| mnepc_o | output | XLEN | RNMI saved PC |
| pc_o | output | XLEN | Next PC |
| priv_o | output | 2 | Privilege after the update |
| virt_o | output | 1 | Virtualization after the update |
| abort_o | output | 1 | Sticky fatal double-trap flag |

## Verification
The bench builds the block with XLEN at 32 and RESET_MIE at 1. This makes the first ordinary trap copy a set MIE into MPIE, so R5 is checked with a non-zero value. RESET_VEC, TRAP_VEC and RNMI_VEC are distinct, so pc_o alone shows which entry path a trap took. Every scenario starts again from reset because NMIE and MDT can only be restored that way. The sequences vary several conditions against each other:
- whether RNMI support and double-trap handling are enabled;
- the pending line and the async flag;
- whether MDT and NMIE are already set or cleared by earlier traps.

These combinations reach all three double-trap outcomes: abort without RNMI support, escalation to RNMI, and abort inside an RNMI handler.

// File: rtl/mtrap_pkg.sv
`timescale 1ns/1ps
package mtrap_pkg;
    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_M = 2'b11;

    // machine status word field positions
    localparam int MS_MIE    = 3;
    localparam int MS_MPIE   = 7;
    localparam int MS_MDT    = 10;
    localparam int MS_MPP_LO = 11;

    // RNMI status word field positions
    localparam int NS_NMIE    = 3;
    localparam int NS_MNPV    = 7;
    localparam int NS_MNPELP  = 9;
    localparam int NS_MNPP_LO = 11;

    typedef enum logic [1:0] {
        PATH_NONE  = 2'd0,
        PATH_MTRAP = 2'd1,
        PATH_RNMI  = 2'd2,
        PATH_ABORT = 2'd3
    } trap_path_e;
endpackage

// File: rtl/mtrap_classify.sv
`timescale 1ns/1ps
module mtrap_classify
    import mtrap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       valid_i,
    input  logic       async_i,
    input  logic       rnmi_en_i,
    input  logic       rnmi_pend_i,
    input  logic       dbl_en_i,
    input  logic       mdt_i,
    input  logic       nmie_i,
    input  logic       halted_i,
    input  logic [1:0] priv_i,
    output trap_path_e path_o,
    output logic       nmi_intr_o
);
    logic in_rnmi_exc;

    always_comb begin
        path_o      = PATH_NONE;
        nmi_intr_o  = 1'b0;
        in_rnmi_exc = rnmi_en_i && !nmie_i && !async_i;
        if (valid_i && !halted_i) begin
            if (rnmi_en_i && rnmi_pend_i && async_i) begin
                path_o     = PATH_RNMI;
                nmi_intr_o = 1'b1;
            end else if (dbl_en_i && mdt_i) begin
                if (!rnmi_en_i || in_rnmi_exc) begin
                    path_o = PATH_ABORT;
                end else begin
                    path_o = PATH_RNMI;
                end
            end else begin
                path_o = PATH_MTRAP;
            end
        end
    end

    // R13: a double trap is only ever seen from machine mode
    p_dbl_in_m_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && dbl_en_i && mdt_i) |-> (priv_i == PRIV_M));

    // R12: no abort decision without double-trap handling
    p_no_abort_wo_dbl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !dbl_en_i |-> (path_o != PATH_ABORT));
endmodule

// File: rtl/mtrap_mframe.sv
`timescale 1ns/1ps
module mtrap_mframe
    import mtrap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] mstatus_i,
    input  logic            async_i,
    input  logic [XLEN-2:0] cause_i,
    input  logic [1:0]      priv_i,
    input  logic            dbl_en_i,
    output logic [XLEN-1:0] mstatus_o,
    output logic [XLEN-1:0] mcause_o
);
    always_comb begin
        mstatus_o                   = mstatus_i;
        mstatus_o[MS_MPIE]          = mstatus_i[MS_MIE];
        mstatus_o[MS_MPP_LO +: 2]   = priv_i;
        mstatus_o[MS_MIE]           = 1'b0;
        if (dbl_en_i) begin
            mstatus_o[MS_MDT] = 1'b1;
        end
        mcause_o = {async_i, cause_i};
    end
endmodule

// File: rtl/mtrap_nframe.sv
`timescale 1ns/1ps
module mtrap_nframe
    import mtrap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] mnstatus_i,
    input  logic [XLEN-2:0] cause_i,
    input  logic            intr_i,
    input  logic [1:0]      priv_i,
    input  logic            virt_i,
    input  logic            lpe_i,
    input  logic            fcfi_en_i,
    output logic [XLEN-1:0] mnstatus_o,
    output logic [XLEN-1:0] mncause_o
);
    always_comb begin
        mnstatus_o                   = mnstatus_i;
        mnstatus_o[NS_NMIE]          = 1'b0;
        mnstatus_o[NS_MNPV]          = intr_i ? virt_i : 1'b0;
        mnstatus_o[NS_MNPP_LO +: 2]  = priv_i;
        if (fcfi_en_i) begin
            mnstatus_o[NS_MNPELP] = lpe_i;
        end
        mncause_o = {intr_i, cause_i};
    end
endmodule

// File: rtl/mtrap_entry_ctrl.sv
`timescale 1ns/1ps
module mtrap_entry_ctrl
    import mtrap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000,
    parameter logic [XLEN-1:0] TRAP_VEC  = 32'h0000_0400,
    parameter logic [XLEN-1:0] RNMI_VEC  = 32'h0000_0800,
    parameter bit              RESET_MIE = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_valid_i,
    input  logic            trap_async_i,
    input  logic [XLEN-2:0] trap_cause_i,
    input  logic [XLEN-1:0] cur_pc_i,
    input  logic [1:0]      cur_priv_i,
    input  logic            cur_virt_i,
    input  logic            lp_expected_i,
    input  logic            fcfi_en_i,
    input  logic            dbltrap_en_i,
    input  logic            rnmi_en_i,
    input  logic            rnmi_pending_i,
    output logic [XLEN-1:0] mstatus_o,
    output logic [XLEN-1:0] mcause_o,
    output logic [XLEN-1:0] mepc_o,
    output logic [XLEN-1:0] mnstatus_o,
    output logic [XLEN-1:0] mncause_o,
    output logic [XLEN-1:0] mnepc_o,
    output logic [XLEN-1:0] pc_o,
    output logic [1:0]      priv_o,
    output logic            virt_o,
    output logic            abort_o
);
    localparam int CAUSE_W = XLEN - 1;
    localparam logic [XLEN-1:0] MSTATUS_RST  = XLEN'(RESET_MIE) << MS_MIE;
    localparam logic [XLEN-1:0] MNSTATUS_RST = XLEN'(1) << NS_NMIE;

    typedef struct packed {
        logic [XLEN-1:0] mstatus;
        logic [XLEN-1:0] mcause;
        logic [XLEN-1:0] mepc;
        logic [XLEN-1:0] mnstatus;
        logic [XLEN-1:0] mncause;
        logic [XLEN-1:0] mnepc;
        logic [XLEN-1:0] pc;
        logic [1:0]      priv;
        logic            virt;
        logic            abort;
    } state_t;

    state_t          st_d, st_q;
    trap_path_e      path;
    logic            nmi_intr;
    logic [XLEN-1:0] m_status_nx, m_cause_nx;
    logic [XLEN-1:0] n_status_nx, n_cause_nx;
    logic [CAUSE_W-1:0] cause_w;

    assign cause_w = trap_cause_i;

    mtrap_classify u_classify (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (trap_valid_i),
        .async_i     (trap_async_i),
        .rnmi_en_i   (rnmi_en_i),
        .rnmi_pend_i (rnmi_pending_i),
        .dbl_en_i    (dbltrap_en_i),
        .mdt_i       (st_q.mstatus[MS_MDT]),
        .nmie_i      (st_q.mnstatus[NS_NMIE]),
        .halted_i    (st_q.abort),
        .priv_i      (cur_priv_i),
        .path_o      (path),
        .nmi_intr_o  (nmi_intr)
    );

    mtrap_mframe #(.XLEN(XLEN)) u_mframe (
        .mstatus_i (st_q.mstatus),
        .async_i   (trap_async_i),
        .cause_i   (cause_w),
        .priv_i    (cur_priv_i),
        .dbl_en_i  (dbltrap_en_i),
        .mstatus_o (m_status_nx),
        .mcause_o  (m_cause_nx)
    );

    mtrap_nframe #(.XLEN(XLEN)) u_nframe (
        .mnstatus_i (st_q.mnstatus),
        .cause_i    (cause_w),
        .intr_i     (nmi_intr),
        .priv_i     (cur_priv_i),
        .virt_i     (cur_virt_i),
        .lpe_i      (lp_expected_i),
        .fcfi_en_i  (fcfi_en_i),
        .mnstatus_o (n_status_nx),
        .mncause_o  (n_cause_nx)
    );

    always_comb begin
        st_d = st_q;
        unique case (path)
            PATH_MTRAP: begin
                st_d.mstatus = m_status_nx;
                st_d.mcause  = m_cause_nx;
                st_d.mepc    = cur_pc_i;
                st_d.pc      = TRAP_VEC;
                st_d.priv    = PRIV_M;
                st_d.virt    = 1'b0;
            end
            PATH_RNMI: begin
                st_d.mnstatus = n_status_nx;
                st_d.mncause  = n_cause_nx;
                st_d.mnepc    = cur_pc_i;
                st_d.pc       = RNMI_VEC;
                st_d.priv     = PRIV_M;
                st_d.virt     = 1'b0;
            end
            PATH_ABORT: begin
                st_d.abort = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mstatus  <= MSTATUS_RST;
            st_q.mcause   <= '0;
            st_q.mepc     <= '0;
            st_q.mnstatus <= MNSTATUS_RST;
            st_q.mncause  <= '0;
            st_q.mnepc    <= '0;
            st_q.pc       <= RESET_VEC;
            st_q.priv     <= PRIV_M;
            st_q.virt     <= 1'b0;
            st_q.abort    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mstatus_o  = st_q.mstatus;
    assign mcause_o   = st_q.mcause;
    assign mepc_o     = st_q.mepc;
    assign mnstatus_o = st_q.mnstatus;
    assign mncause_o  = st_q.mncause;
    assign mnepc_o    = st_q.mnepc;
    assign pc_o       = st_q.pc;
    assign priv_o     = st_q.priv;
    assign virt_o     = st_q.virt;
    assign abort_o    = st_q.abort;

    // R10: abort never drops without reset
    p_abort_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> abort_o);

    // R8: an abort decision freezes the status word and raises the flag
    p_abort_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (path == PATH_ABORT) |=> (abort_o && $stable(mstatus_o) && $stable(pc_o)));

    // R4: RNMI entry lands in M mode, unvirtualized, with NMIE cleared
    p_rnmi_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (path == PATH_RNMI) |=> (priv_o == PRIV_M && !virt_o && !mnstatus_o[NS_NMIE]
                                 && pc_o == RNMI_VEC));

    // R7: ordinary entry with double-trap handling sets MDT
    p_mdt_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (path == PATH_MTRAP && dbltrap_en_i) |=> mstatus_o[MS_MDT]);

    // R11: idle cycles hold all state
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid_i |=> ($stable(pc_o) && $stable(mcause_o) && $stable(mncause_o)
                           && $stable(mstatus_o) && $stable(mnstatus_o)));
endmodule

// File: tb/mtrap_entry_ctrl_bench.sv
`timescale 1ns/1ps
module mtrap_entry_ctrl_bench;
    localparam int XLEN = 32;
    localparam logic [XLEN-1:0] RESET_VEC = 32'h0000_1000;
    localparam logic [XLEN-1:0] TRAP_VEC  = 32'h0000_0400;
    localparam logic [XLEN-1:0] RNMI_VEC  = 32'h0000_0800;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trap_valid_i = 1'b0, trap_async_i = 1'b0;
    logic [XLEN-2:0] trap_cause_i = '0;
    logic [XLEN-1:0] cur_pc_i = '0;
    logic [1:0]      cur_priv_i = 2'b11;
    logic            cur_virt_i = 1'b0, lp_expected_i = 1'b0, fcfi_en_i = 1'b0;
    logic            dbltrap_en_i = 1'b0, rnmi_en_i = 1'b0, rnmi_pending_i = 1'b0;
    logic [XLEN-1:0] mstatus_o, mcause_o, mepc_o, mnstatus_o, mncause_o, mnepc_o, pc_o;
    logic [1:0]      priv_o;
    logic            virt_o, abort_o;

    always #2 clk = ~clk;

    mtrap_entry_ctrl #(.XLEN(XLEN), .RESET_VEC(RESET_VEC), .TRAP_VEC(TRAP_VEC),
                       .RNMI_VEC(RNMI_VEC), .RESET_MIE(1'b1)) u_mtrap_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .trap_valid_i(trap_valid_i), .trap_async_i(trap_async_i),
        .trap_cause_i(trap_cause_i), .cur_pc_i(cur_pc_i), .cur_priv_i(cur_priv_i),
        .cur_virt_i(cur_virt_i), .lp_expected_i(lp_expected_i), .fcfi_en_i(fcfi_en_i),
        .dbltrap_en_i(dbltrap_en_i), .rnmi_en_i(rnmi_en_i), .rnmi_pending_i(rnmi_pending_i),
        .mstatus_o(mstatus_o), .mcause_o(mcause_o), .mepc_o(mepc_o), .mnstatus_o(mnstatus_o),
        .mncause_o(mncause_o), .mnepc_o(mnepc_o), .pc_o(pc_o), .priv_o(priv_o),
        .virt_o(virt_o), .abort_o(abort_o)
    );

    // expected state
    logic [XLEN-1:0] e_ms, e_mc, e_me, e_ns, e_nc, e_ne, e_pc;
    logic [1:0]      e_priv;
    logic            e_virt, e_abort;
    string           e_tag;
    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "mstatus", mstatus_o, e_ms);
        chk(tag, "mcause", mcause_o, e_mc);
        chk(tag, "mepc", mepc_o, e_me);
        chk(tag, "mnstatus", mnstatus_o, e_ns);
        chk(tag, "mncause", mncause_o, e_nc);
        chk(tag, "mnepc", mnepc_o, e_ne);
        chk(tag, "pc", pc_o, e_pc);
        chk(tag, "priv", XLEN'(priv_o), XLEN'(e_priv));
        chk(tag, "virt", XLEN'(virt_o), XLEN'(e_virt));
        chk(tag, "abort", XLEN'(abort_o), XLEN'(e_abort));
    endtask

    // 0 idle, 1 ordinary, 2 rnmi pending, 3 rnmi escalated, 4 abort
    function automatic int pick_path(logic v, logic as, logic dbl, logic rn, logic pend,
                                     logic mdt, logic nmie, logic halted);
        if (!v || halted) return 0;
        if (rn && pend && as) return 2;
        if (dbl && mdt) begin
            if (!rn || (!nmie && !as)) return 4;
            return 3;
        end
        return 1;
    endfunction

    task automatic model_apply();
        int p;
        p = pick_path(trap_valid_i, trap_async_i, dbltrap_en_i, rnmi_en_i, rnmi_pending_i,
                      e_ms[10], e_ns[3], e_abort);
        case (p)
            0: e_tag = e_abort ? "R10" : "R11";
            1: begin
                e_tag = dbltrap_en_i ? "R7" : "R5";
                e_ms[7] = e_ms[3];
                e_ms[12:11] = cur_priv_i;
                e_ms[3] = 1'b0;
                if (dbltrap_en_i) e_ms[10] = 1'b1;
                e_mc = {trap_async_i, trap_cause_i};
                e_me = cur_pc_i;
                e_pc = TRAP_VEC;
                e_priv = 2'b11;
                e_virt = 1'b0;
            end
            2, 3: begin
                e_tag = (p == 2) ? "R2" : "R9";
                e_ns[3] = 1'b0;
                e_ns[7] = (p == 2) ? cur_virt_i : 1'b0;
                e_ns[12:11] = cur_priv_i;
                if (fcfi_en_i) e_ns[9] = lp_expected_i;
                e_nc = {(p == 2), trap_cause_i};
                e_ne = cur_pc_i;
                e_pc = RNMI_VEC;
                e_priv = 2'b11;
                e_virt = 1'b0;
            end
            default: begin
                e_tag = "R8";
                e_abort = 1'b1;
            end
        endcase
    endtask

    task automatic step(logic v, logic as, logic [XLEN-2:0] cause, logic [XLEN-1:0] pc,
                        logic [1:0] priv, logic virt, logic lpe, logic fc,
                        logic dbl, logic rn, logic pend);
        trap_valid_i = v; trap_async_i = as; trap_cause_i = cause; cur_pc_i = pc;
        cur_priv_i = priv; cur_virt_i = virt; lp_expected_i = lpe; fcfi_en_i = fc;
        dbltrap_en_i = dbl; rnmi_en_i = rn; rnmi_pending_i = pend;
        model_apply();
        @(negedge clk);
        check_all(e_tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        trap_valid_i = 1'b0;
        cur_priv_i = 2'b11;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        e_ms = 32'h8; e_mc = '0; e_me = '0; e_ns = 32'h8; e_nc = '0; e_ne = '0;
        e_pc = RESET_VEC; e_priv = 2'b11; e_virt = 1'b0; e_abort = 1'b0;
        check_all("R1");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        do_reset();

        // R5 R6 R12: ordinary sync trap from U, double-trap handling off
        step(1, 0, 31'd5, 32'h100, 2'b00, 1, 0, 0, 0, 0, 0);
        chk("R5", "mpie", XLEN'(mstatus_o[7]), 32'd1);
        chk("R6", "mcause", mcause_o, 32'h0000_0005);
        chk("R12", "mdt", XLEN'(mstatus_o[10]), 32'd0);
        // R11: idle
        step(0, 1, 31'd9, 32'h200, 2'b11, 0, 0, 0, 1, 1, 1);

        // R7 R6 then R8 (no RNMI support) then R10
        do_reset();
        step(1, 1, 31'd7, 32'h300, 2'b01, 0, 0, 0, 1, 0, 0);
        chk("R7", "mdt", XLEN'(mstatus_o[10]), 32'd1);
        chk("R6", "mcause_async", mcause_o, 32'h8000_0007);
        step(1, 0, 31'd2, 32'h340, 2'b11, 0, 0, 0, 1, 0, 0);
        chk("R8", "abort", XLEN'(abort_o), 32'd1);
        step(1, 0, 31'd3, 32'h380, 2'b11, 0, 0, 0, 0, 0, 0);
        chk("R10", "pc", pc_o, TRAP_VEC);

        // R2 R3 R4: pending RNMI from virtualized S
        do_reset();
        step(1, 1, 31'd13, 32'h500, 2'b01, 1, 1, 1, 0, 1, 1);
        chk("R2", "mncause", mncause_o, 32'h8000_000d);
        chk("R3", "mnpelp", XLEN'(mnstatus_o[9]), 32'd1);
        chk("R4", "priv", XLEN'(priv_o), 32'd3);

        // R3: forward-CFI off keeps MNPELP
        do_reset();
        step(1, 1, 31'd11, 32'h520, 2'b00, 0, 1, 0, 0, 1, 1);
        chk("R3", "mnpelp_kept", XLEN'(mnstatus_o[9]), 32'd0);

        // R9 then R8 inside RNMI context
        do_reset();
        step(1, 0, 31'd4, 32'h600, 2'b00, 0, 0, 0, 1, 1, 0);
        step(1, 0, 31'd6, 32'h640, 2'b11, 0, 0, 0, 1, 1, 0);
        chk("R9", "mncause_raw", mncause_o, 32'h0000_0006);
        chk("R9", "mnpv", XLEN'(mnstatus_o[7]), 32'd0);
        step(1, 0, 31'd8, 32'h680, 2'b11, 0, 0, 0, 1, 1, 0);
        chk("R8", "abort_in_rnmi", XLEN'(abort_o), 32'd1);

        // constrained random episodes
        for (int ep = 0; ep < 150; ep++) begin
            do_reset();
            for (int k = 0; k < 30; k++) begin
                logic [1:0] pr;
                pr = 2'($urandom_range(0, 2));
                if (pr == 2'b10) pr = 2'b11;
                if (e_ms[10]) pr = 2'b11;
                step(($urandom_range(0, 9) < 6), 1'($urandom), 31'($urandom),
                     {$urandom} & 32'hffff_fffc, pr, 1'($urandom), 1'($urandom),
                     1'($urandom), ($urandom_range(0, 3) != 0), 1'($urandom),
                     1'($urandom));
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule